// File: doc/BRIEF.md
# Time-of-Day Transfer Target Controller

This block decides which processor core on a chip receives the chip-wide time-of-day value. It also launches the copy of that value into the chosen core's timebase. Software writes a 64-bit target-control word through a simple register-write port. The word names the destination core in one of two ways:

- **Full-address mode:** the word carries a complete register-bus address. Its page must match one core's base address, and its in-page offset must point at the core's time-of-day register.
- **Core-ID mode:** the word carries a small core identifier, which is matched against the identifiers of the cores that are present.

The decoded core index and a valid flag are held in a target register.

A separate write to the move register asks for the transfer. The move goes ahead only when four conditions all hold: the time-of-day logic is running, the request bit is set, a valid target is held, and that core says it is ready to receive. When the move goes ahead, the controller raises a one-cycle sent strobe toward the target core. When it does not, the controller records why in a sticky error register, which software clears by writing ones.

Core base addresses, core identifiers, presence and readiness all arrive on input ports. One parameter switches off core-ID mode for chip variants that only address cores through the bus.

Top module: `tod_xfer_ctrl`

## Requirements
- R1: After synchronous reset, `tgt_valid` is 0, `tgt_index` is 0, `err_flags` is 0 and `sent_pulse` is 0.
- R2: Writes use `wr_sel`: 0 loads the target-control word, 1 requests a move, 2 clears errors, and 3 has no effect. Target-word bit 28 (bit 35 counting from the MSB) selects full-address mode when it is 1. In that mode the address is `wr_data[63:32]`. If the address's low 12 bits differ from the offset parameter (default 12'h040), the target is invalid.
- R3: In full-address mode with a correct offset, the target is the lowest-index present core whose base equals the address with its low 12 bits cleared. If no present core matches, the target is invalid.
- R4: In core-ID mode, the low 5 bits of the field `wr_data[39:32]` are compared with the IDs of present cores. The lowest-index match becomes the target; no match makes it invalid.
- R5: With core-ID mode disabled by parameter, every core-ID-mode target write yields an invalid target.
- R6: `tgt_valid` and `tgt_index` change only on the clock edge that takes a `wr_sel`=0 write. They are visible from the next cycle and hold through any other write.
- R7: A move write is accepted when all of these hold: `tod_running` is 1, `wr_data[63]` (bit 0 counting from the MSB) is 1, the target is valid, and `core_ready[tgt_index]` is 1. Acceptance drives `sent_pulse` one-hot at `tgt_index` for exactly the cycle after the write edge.
- R8: A rejected move sets exactly one sticky error bit, the first failing check in this order: bit 0 not running, bit 1 request bit clear, bit 2 no valid target, bit 3 target not ready. No sent pulse is produced.
- R9: A target write that yields an invalid target sets error bit 4.
- R10: Error bits stay set until a `wr_sel`=2 write carries a 1 in the matching position of `wr_data[4:0]`. Bits written as 0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 target, 1 move, 2 error clear, 3 none) |
| wr_data | input | 64 | Write data |
| tod_running | input | 1 | Time-of-day logic is in the running state |
| core_present | input | NUM_CORES | Core exists on this chip |
| core_base | input | NUM_CORES*32 | Per-core register-bus base addresses |
| core_id | input | NUM_CORES*5 | Per-core identifiers |
| core_ready | input | NUM_CORES | Core timebase ready to receive time-of-day |
| tgt_valid | output | 1 | Held target is valid |
| tgt_index | output | $clog2(NUM_CORES) | Held target core index |
| sent_pulse | output | NUM_CORES | One-cycle sent-to-timebase strobe per core |
| err_flags | output | 5 | Sticky error bits |

## Verification
The hardest situation to reach is a move rejected by two or more conditions at once, because only the first failing check may be logged. The stimulus reaches it by dropping the running state and the request bit together, and then by pointing at an absent core while the target is not ready. Ties between cores are provoked by briefly giving two cores the same base address. The variant without core-ID mode is driven by the same words through a second instance.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;

    typedef enum logic [1:0] {
        SEL_TARGET = 2'd0,
        SEL_MOVE   = 2'd1,
        SEL_ERRCLR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Convert MSB-first bit numbering of a 64-bit word to a vector index.
    function automatic int msb0(input int n);
        return 63 - n;
    endfunction

    localparam int MODE_BIT  = msb0(35);
    localparam int REQ_BIT   = msb0(0);
    localparam int ADDR_LSB  = 32;
    localparam int ADDR_W    = 32;
    localparam int OFS_W     = 12;
    localparam int ID_W      = 5;
    localparam int ERR_W     = 5;

    // Field order puts not_running at bit 0.
    typedef struct packed {
        logic bad_tgt_wr;
        logic not_ready;
        logic no_target;
        logic req_clear;
        logic not_running;
    } err_t;

endpackage

// File: rtl/tod_tgt_decode.sv
module tod_tgt_decode
    import tod_xfer_pkg::*;
#(
    parameter int          NUM_CORES  = 8,
    parameter int          IDX_W      = 3,
    parameter logic [11:0] REG_OFS    = 12'h040,
    parameter bit          ID_MODE_EN = 1'b1
) (
    input  logic [63:0]               word,
    input  logic [NUM_CORES-1:0]      present,
    input  logic [NUM_CORES*ADDR_W-1:0] bases,
    input  logic [NUM_CORES*ID_W-1:0] ids,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx
);
    logic [ADDR_W-1:0]    addr;
    logic [ADDR_W-1:0]    page;
    logic [ID_W-1:0]      sel_id;
    logic                 full_mode;
    logic                 ofs_ok;
    logic [NUM_CORES-1:0] match;

    assign addr      = word[ADDR_LSB +: ADDR_W];
    assign page      = {addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign sel_id    = word[ADDR_LSB +: ID_W];
    assign full_mode = word[MODE_BIT];
    assign ofs_ok    = (addr[OFS_W-1:0] == REG_OFS);

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_cmp
        logic base_eq;
        logic id_eq;
        assign base_eq = (bases[i*ADDR_W +: ADDR_W] == page);
        if (ID_MODE_EN) begin : g_id
            assign id_eq = (ids[i*ID_W +: ID_W] == sel_id);
        end else begin : g_noid
            assign id_eq = 1'b0;
        end
        assign match[i] = present[i] & (full_mode ? (ofs_ok & base_eq) : id_eq);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tod_move_gate.sv
module tod_move_gate
    import tod_xfer_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 move_wr,
    input  logic                 req_bit,
    input  logic                 running,
    input  logic                 tgt_ok,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  logic [NUM_CORES-1:0] ready,
    output logic                 accept,
    output err_t                 reject
);
    logic tgt_ready;

    assign tgt_ready = ready[tgt_idx];

    always_comb begin
        accept = 1'b0;
        reject = '0;
        if (move_wr) begin
            if (!running)        reject.not_running = 1'b1;
            else if (!req_bit)   reject.req_clear   = 1'b1;
            else if (!tgt_ok)    reject.no_target   = 1'b1;
            else if (!tgt_ready) reject.not_ready   = 1'b1;
            else                 accept             = 1'b1;
        end
    end

endmodule

// File: rtl/tod_err_sticky.sv
module tod_err_sticky
    import tod_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  err_t             set,
    input  logic             clr_wr,
    input  logic [ERR_W-1:0] clr_mask,
    output logic [ERR_W-1:0] flags
);
    logic [ERR_W-1:0] kept;

    assign kept = clr_wr ? (flags & ~clr_mask) : flags;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= kept | set;
    end

endmodule

// File: rtl/tod_xfer_ctrl.sv
module tod_xfer_ctrl
    import tod_xfer_pkg::*;
#(
    parameter int          NUM_CORES  = 8,
    parameter logic [11:0] REG_OFS    = 12'h040,
    parameter bit          ID_MODE_EN = 1'b1,
    localparam int         IDX_W      = $clog2(NUM_CORES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [63:0]                 wr_data,
    input  logic                        tod_running,
    input  logic [NUM_CORES-1:0]        core_present,
    input  logic [NUM_CORES*32-1:0]     core_base,
    input  logic [NUM_CORES*5-1:0]      core_id,
    input  logic [NUM_CORES-1:0]        core_ready,
    output logic                        tgt_valid,
    output logic [IDX_W-1:0]            tgt_index,
    output logic [NUM_CORES-1:0]        sent_pulse,
    output logic [ERR_W-1:0]            err_flags
);
    logic             tgt_wr, move_wr, clr_wr;
    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             accept;
    err_t             move_rej;
    err_t             err_set;

    assign tgt_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_TARGET);
    assign move_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MOVE);
    assign clr_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_ERRCLR);

    tod_tgt_decode #(
        .NUM_CORES (NUM_CORES),
        .IDX_W     (IDX_W),
        .REG_OFS   (REG_OFS),
        .ID_MODE_EN(ID_MODE_EN)
    ) u_dec (
        .word   (wr_data),
        .present(core_present),
        .bases  (core_base),
        .ids    (core_id),
        .hit    (dec_hit),
        .idx    (dec_idx)
    );

    tod_move_gate #(
        .NUM_CORES(NUM_CORES),
        .IDX_W    (IDX_W)
    ) u_gate (
        .move_wr(move_wr),
        .req_bit(wr_data[REQ_BIT]),
        .running(tod_running),
        .tgt_ok (tgt_valid),
        .tgt_idx(tgt_index),
        .ready  (core_ready),
        .accept (accept),
        .reject (move_rej)
    );

    always_comb begin
        err_set            = move_rej;
        err_set.bad_tgt_wr = tgt_wr && !dec_hit;
    end

    tod_err_sticky u_err (
        .clk     (clk),
        .rst     (rst),
        .set     (err_set),
        .clr_wr  (clr_wr),
        .clr_mask(wr_data[ERR_W-1:0]),
        .flags   (err_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_valid  <= 1'b0;
            tgt_index  <= '0;
            sent_pulse <= '0;
        end else begin
            if (tgt_wr) begin
                tgt_valid <= dec_hit;
                tgt_index <= dec_hit ? dec_idx : '0;
            end
            sent_pulse <= accept ? (NUM_CORES'(1) << tgt_index) : '0;
        end
    end

endmodule

// File: rtl/tod_xfer_ctrl_chk.sv
module tod_xfer_ctrl_chk #(
    parameter int NUM_CORES = 8,
    parameter int IDX_W     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic [63:0]          wr_data,
    input logic                 tod_running,
    input logic [NUM_CORES-1:0] core_ready,
    input logic                 tgt_valid,
    input logic [IDX_W-1:0]     tgt_index,
    input logic [NUM_CORES-1:0] sent_pulse,
    input logic [4:0]           err_flags
);
    logic [4:0] clr_m;
    logic       ctl_wr;
    logic       good_move;

    assign clr_m     = (wr_en && wr_sel == 2'd2) ? wr_data[4:0] : 5'd0;
    assign ctl_wr    = wr_en && (wr_sel == 2'd0);
    assign good_move = wr_en && (wr_sel == 2'd1) && wr_data[63] && tod_running && tgt_valid;

    AST_TGT_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tgt_valid);                                          // R1

    AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_wr) |-> ($stable(tgt_valid) && $stable(tgt_index)));     // R6

    AST_SENT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sent_pulse));                                               // R7

    AST_SENT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (sent_pulse != '0) |-> $past(good_move));                            // R7

    AST_SENT_READY: assert property (@(posedge clk) disable iff (rst)
        (sent_pulse & ~$past(core_ready)) == '0);                            // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(err_flags) & ~$past(clr_m) & ~err_flags) == 5'd0);            // R10

endmodule

bind tod_xfer_ctrl tod_xfer_ctrl_chk #(
    .NUM_CORES(NUM_CORES),
    .IDX_W    (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .tod_running(tod_running),
    .core_ready (core_ready),
    .tgt_valid  (tgt_valid),
    .tgt_index  (tgt_index),
    .sent_pulse (sent_pulse),
    .err_flags  (err_flags)
);

// File: tb/tod_xfer_ctrl_test.sv
module tod_xfer_ctrl_test;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_sel = 2'd3;
    logic [63:0]    wr_data = '0;
    logic           tod_running = 1'b1;
    logic [N-1:0]   core_present;
    logic [N*32-1:0] core_base;
    logic [N*5-1:0] core_id;
    logic [N-1:0]   core_ready = '1;
    logic           tgt_valid, tgt_valid2;
    logic [2:0]     tgt_index, tgt_index2;
    logic [N-1:0]   sent_pulse, sent_pulse2;
    logic [4:0]     err_flags, err_flags2;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tod_xfer_ctrl #(.NUM_CORES(N)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tod_running(tod_running), .core_present(core_present), .core_base(core_base),
        .core_id(core_id), .core_ready(core_ready), .tgt_valid(tgt_valid),
        .tgt_index(tgt_index), .sent_pulse(sent_pulse), .err_flags(err_flags)
    );

    tod_xfer_ctrl #(.NUM_CORES(N), .ID_MODE_EN(1'b0)) uut2 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tod_running(tod_running), .core_present(core_present), .core_base(core_base),
        .core_id(core_id), .core_ready(core_ready), .tgt_valid(tgt_valid2),
        .tgt_index(tgt_index2), .sent_pulse(sent_pulse2), .err_flags(err_flags2)
    );

    typedef struct packed {
        logic [63:0] word;
        logic        valid;
        logic [2:0]  idx;
        logic        valid_noid;
    } vec_t;

    // Core i: base 0x2i00_0000, id 2*i+1; core 5 absent.
    localparam vec_t VECS [10] = '{
        '{64'h2000_0040_1000_0000, 1'b1, 3'd0, 1'b1},  // R2 R3 full, core 0
        '{64'h2700_0040_1000_0000, 1'b1, 3'd7, 1'b1},  // R3 full, core 7
        '{64'h2300_0044_1000_0000, 1'b0, 3'd0, 1'b0},  // R2 bad offset
        '{64'h3000_0040_1000_0000, 1'b0, 3'd0, 1'b0},  // R3 no page match
        '{64'h2500_0040_1000_0000, 1'b0, 3'd0, 1'b0},  // R3 absent core
        '{64'h0000_0003_0000_0000, 1'b1, 3'd1, 1'b0},  // R4 id 3
        '{64'h0000_0023_0000_0000, 1'b1, 3'd1, 1'b0},  // R4 masked to 5 bits
        '{64'h0000_000F_0000_0000, 1'b1, 3'd7, 1'b0},  // R4 id 15
        '{64'h0000_000B_0000_0000, 1'b0, 3'd0, 1'b0},  // R4 absent core id
        '{64'h0000_0004_0000_0000, 1'b0, 3'd0, 1'b0}   // R4 unknown id
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        core_present = 8'b1101_1111;
        for (int i = 0; i < N; i++) begin
            core_base[i*32 +: 32] = 32'h2000_0000 + 32'(i) * 32'h0100_0000;
            core_id[i*5 +: 5]     = 5'(2 * i + 1);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tgt_valid == 1'b0 && tgt_index == 3'd0, "R1 target", {tgt_valid, tgt_index}, 0);
        chk(err_flags == 5'd0 && sent_pulse == '0, "R1 err/sent", {err_flags, sent_pulse}, 0);

        foreach (VECS[k]) begin
            wr(2'd0, VECS[k].word);
            chk(tgt_valid == VECS[k].valid && tgt_index == VECS[k].idx, "R2 R3 R4 R6 decode",
                {tgt_valid, tgt_index}, {VECS[k].valid, VECS[k].idx});
            chk(err_flags == {!VECS[k].valid, 4'b0}, "R9 bad target error",
                err_flags, {!VECS[k].valid, 4'b0});
            chk(tgt_valid2 == VECS[k].valid_noid && err_flags2[4] == !VECS[k].valid_noid,
                "R5 no-id variant", {tgt_valid2, err_flags2}, {VECS[k].valid_noid, !VECS[k].valid_noid});
            wr(2'd2, 64'h1F);
            chk(err_flags == 5'd0, "R10 clear all", err_flags, 0);
        end

        // R3 tie: two cores share a base, lowest index wins
        core_base[3*32 +: 32] = 32'h2200_0000;
        wr(2'd0, 64'h2200_0040_1000_0000);
        chk(tgt_valid && tgt_index == 3'd2, "R3 lowest index", tgt_index, 2);
        core_base[3*32 +: 32] = 32'h2300_0000;

        // R7 accepted move to core 1
        wr(2'd0, 64'h0000_0003_0000_0000);
        wr(2'd1, 64'h8000_0000_0000_0000);
        chk(sent_pulse == 8'b0000_0010 && err_flags == 0, "R7 sent pulse", sent_pulse, 8'h02);
        @(negedge clk);
        chk(sent_pulse == '0, "R7 single cycle", sent_pulse, 0);

        // R6 other writes leave the target unchanged
        wr(2'd3, 64'h2700_0040_1000_0000);
        wr(2'd2, 64'h1F);
        chk(tgt_valid && tgt_index == 3'd1 && err_flags == 0, "R6 hold", {tgt_valid, tgt_index}, 4'h9);

        // R8 reject priority
        tod_running = 1'b0;
        wr(2'd1, 64'h0);
        chk(err_flags == 5'b00001 && sent_pulse == 0, "R8 not running first", err_flags, 1);
        tod_running = 1'b1;
        wr(2'd1, 64'h0);
        chk(err_flags == 5'b00011 && sent_pulse == 0, "R8 req clear", err_flags, 3);
        core_ready[1] = 1'b0;
        wr(2'd1, 64'h8000_0000_0000_0000);
        chk(err_flags == 5'b01011 && sent_pulse == 0, "R8 not ready", err_flags, 11);
        wr(2'd0, 64'h0000_0004_0000_0000);
        wr(2'd1, 64'h8000_0000_0000_0000);
        chk(err_flags == 5'b11111 && sent_pulse == 0, "R8 no target before ready", err_flags, 31);
        core_ready[1] = 1'b1;

        // R10 partial clear keeps unwritten bits
        wr(2'd2, 64'h05);
        chk(err_flags == 5'b11010, "R10 partial clear", err_flags, 5'b11010);

        // R1 reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!tgt_valid && err_flags == 0, "R1 reset again", {tgt_valid, err_flags}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule